// File: doc/BRIEF.md
# Periodic Rollover Status and Interrupt

This block keeps one sticky flag for each rate of a timekeeping counter chain: hundredths, tenths, seconds, minutes, hours and days. The counter chain sends a one-cycle strobe whenever a counter wraps. The matching flag is set and stays set until the host reads the status register. That read returns the flags and clears them in the same access.

Host software uses the flags to check a multi-byte time read for a torn value. It first does a throwaway read to clear the flags. It then reads the counter bytes and reads the status again. If the flag for the fastest counter it sampled is set, it repeats the read.

A mask register enables an interrupt for each rate. The active-low interrupt line is low while any flag that is set is also enabled. With the hundredths rate enabled, the line fires every 10 ms.

Top module: `rollover_status`

## Requirements
- R1: After reset, all flags and all mask bits are zero and `irqN` is high.
- R2: A strobe on `rollStrobe[i]` sets flag bit i after the next clock edge. The bit layout is: bit0 hundredths, bit1 tenths, bit2 seconds, bit3 minutes, bit4 hours, bit5 days.
- R3: A set flag stays set, with no strobe needed, until a status read.
- R4: A read with `rdEn` high and `rdAddr` at the status address (0) returns the flags on `rdData` in the same cycle. All flags are cleared at the following clock edge.
- R5: A strobe that arrives in the same cycle as a status read does not show in that read's data, and its flag is set after the clear.
- R6: Bits of `rdData` above the rate bits (bits 7:6) always read as zero.
- R7: A write with `wrEn` high and `wrAddr` at the mask address (1) loads `wrData[5:0]` into the mask. A read at address 1 returns the mask. Writes to any other address leave the mask unchanged.
- R8: `irqN` is low exactly when some flag bit is set and its mask bit is 1. A flag that is set but not enabled leaves `irqN` high.
- R9: After a status read with no strobe in that cycle, `irqN` is high in the next cycle.
- R10: `rdData` is zero when `rdEn` is low or `rdAddr` matches neither the status nor the mask address, and a read at an unmatched address clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rollStrobe | input | NUM_RATES | One-cycle rollover strobes, one per rate |
| rdEn | input | 1 | Bus read strobe |
| rdAddr | input | ADDR_W | Read address |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid in the cycle of the read |
| irqN | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: six rates, an 8-bit data bus and a 4-bit address. The bus being wider than the rate count leaves two padding bits whose read-as-zero rule can be observed. The 4-bit address leaves spare addresses, so reads and writes that decode to neither register can be applied and shown to have no effect. Status and mask addresses 0 and 1 let one vector table cover the cases where a clear and a strobe meet, and where a flag is set but masked.

// File: rtl/rollover_pkg.sv
package rollover_pkg;
  // Decoded bus strobes passed from control to datapath
  typedef struct packed {
    logic clrStatus;
    logic loadMask;
    logic selStatus;
    logic selMask;
  } ctl_t;
endpackage

// File: rtl/rollover_ctl.sv
module rollover_ctl
  import rollover_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR   = 1
) (
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctl_t              ctl
);
  localparam logic [ADDR_W-1:0] StatusA = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] MaskA   = ADDR_W'(MASK_ADDR);

  always_comb begin
    ctl.selStatus = rdEn && (rdAddr == StatusA);
    ctl.selMask   = rdEn && (rdAddr == MaskA);
    ctl.clrStatus = ctl.selStatus;
    ctl.loadMask  = wrEn && (wrAddr == MaskA);
  end
endmodule

// File: rtl/rollover_dp.sv
module rollover_dp
  import rollover_pkg::*;
#(
  parameter int NUM_RATES = 6,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RATES-1:0] rollStrobe,
  input  ctl_t                 ctl,
  input  logic [NUM_RATES-1:0] maskIn,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqN,
  output logic [NUM_RATES-1:0] statusQ,
  output logic [NUM_RATES-1:0] maskQ
);
  localparam int PadW = DATA_W - NUM_RATES;

  // One sticky flag per rate: the clear comes first, then the strobe is ORed in
  for (genvar i = 0; i < NUM_RATES; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= (statusQ[i] & ~ctl.clrStatus) | rollStrobe[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             maskQ <= '0;
    else if (ctl.loadMask) maskQ <= maskIn;
  end

  logic [NUM_RATES-1:0] rateData;
  always_comb begin
    rateData = '0;
    if (ctl.selStatus)    rateData = statusQ;
    else if (ctl.selMask) rateData = maskQ;
  end

  if (PadW > 0) begin : g_pad
    assign rdData = {{PadW{1'b0}}, rateData};
  end else begin : g_nopad
    assign rdData = rateData[DATA_W-1:0];
  end

  assign irqN = ~|(statusQ & maskQ);
endmodule

// File: rtl/rollover_status.sv
module rollover_status
  import rollover_pkg::*;
#(
  parameter int NUM_RATES   = 6,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR   = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RATES-1:0] rollStrobe,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqN
);
  ctl_t                 ctl;
  logic [NUM_RATES-1:0] statusQ;
  logic [NUM_RATES-1:0] maskQ;

  rollover_ctl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .MASK_ADDR(MASK_ADDR)
  ) i_ctl (
    .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr), .ctl(ctl)
  );

  rollover_dp #(
    .NUM_RATES(NUM_RATES), .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .rollStrobe(rollStrobe), .ctl(ctl),
    .maskIn(wrData[NUM_RATES-1:0]), .rdData(rdData), .irqN(irqN),
    .statusQ(statusQ), .maskQ(maskQ)
  );
endmodule

// File: rtl/rollover_status_checker.sv
module rollover_status_checker #(
  parameter int NUM_RATES   = 6,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_RATES-1:0] rollStrobe,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    rdAddr,
  input logic [DATA_W-1:0]    rdData,
  input logic                 irqN,
  input logic [NUM_RATES-1:0] statusQ
);
  logic statusRead;
  assign statusRead = rdEn && (rdAddr == ADDR_W'(STATUS_ADDR));

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rollStrobe != '0) |=> ((statusQ & $past(rollStrobe)) == $past(rollStrobe)));

  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!statusRead && rollStrobe == '0) |=> $stable(statusQ));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && rollStrobe == '0) |=> (statusQ == '0));

  assert_strobe_survives_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && rollStrobe != '0) |=> (statusQ == $past(rollStrobe)));

  assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:NUM_RATES] == '0);

  assert_irq_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && rollStrobe == '0) |=> irqN);
endmodule

bind rollover_status rollover_status_checker #(
  .NUM_RATES(NUM_RATES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) i_checker (
  .clk(clk), .rstN(rstN), .rollStrobe(rollStrobe), .rdEn(rdEn), .rdAddr(rdAddr),
  .rdData(rdData), .irqN(irqN), .statusQ(statusQ)
);

// File: tb/test_rollover_status.sv
module test_rollover_status;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] rollStrobe = '0;
  logic       rdEn = 1'b0;
  logic [3:0] rdAddr = '0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rollover_status i_rollover_status (
    .clk(clk), .rstN(rstN), .rollStrobe(rollStrobe), .rdEn(rdEn), .rdAddr(rdAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdData(rdData), .irqN(irqN)
  );

  typedef struct packed {
    logic [5:0] strobe;
    logic       rd;
    logic [3:0] ra;
    logic       wr;
    logic [3:0] wa;
    logic [7:0] wd;
    logic [7:0] expRd;
    logic       expIrqN;
    logic [7:0] req;
  } vec_t;

  // Inputs applied in a cycle; expected values observed in that same cycle before its edge
  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 1'b1, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd1 },  // R1 empty after reset
    '{6'h01, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd10},  // R10 no read, zero data
    '{6'h00, 1'b1, 4'h0, 1'b0, 4'h0, 8'h00, 8'h01, 1'b1, 8'd2 },  // R2 hundredths -> bit0
    '{6'h00, 1'b1, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd4 },  // R4 cleared by read
    '{6'h04, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd2 },  // R2 seconds strobe
    '{6'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd3 },
    '{6'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd3 },
    '{6'h00, 1'b1, 4'h0, 1'b0, 4'h0, 8'h00, 8'h04, 1'b1, 8'd3 },  // R3 held to read, bit2
    '{6'h00, 1'b0, 4'h0, 1'b1, 4'h1, 8'hFF, 8'h00, 1'b1, 8'd7 },  // R7 mask write
    '{6'h00, 1'b1, 4'h1, 1'b0, 4'h0, 8'h00, 8'h3F, 1'b1, 8'd7 },  // R7 mask readback
    '{6'h00, 1'b0, 4'h0, 1'b1, 4'h0, 8'h00, 8'h00, 1'b1, 8'd7 },  // R7 write elsewhere
    '{6'h00, 1'b1, 4'h1, 1'b1, 4'h5, 8'h00, 8'h3F, 1'b1, 8'd7 },  // R7 mask unchanged
    '{6'h20, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd8 },  // R8 days strobe
    '{6'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 8'd8 },  // R8 irq asserted
    '{6'h10, 1'b1, 4'h0, 1'b0, 4'h0, 8'h00, 8'h20, 1'b0, 8'd5 },  // R5 read+hours strobe
    '{6'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 8'd5 },  // R5 hours kept
    '{6'h00, 1'b1, 4'h0, 1'b0, 4'h0, 8'h00, 8'h10, 1'b0, 8'd5 },  // R5 bit4 only
    '{6'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd9 },  // R9 irq released
    '{6'h00, 1'b0, 4'h0, 1'b1, 4'h1, 8'h02, 8'h00, 1'b1, 8'd7 },  // R7 mask tenths only
    '{6'h01, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd8 },
    '{6'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd8 },  // R8 masked flag, no irq
    '{6'h3F, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd8 },
    '{6'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 8'd8 },  // R8 enabled flag, irq
    '{6'h00, 1'b1, 4'h3, 1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 8'd10},  // R10 unmatched read
    '{6'h00, 1'b1, 4'h0, 1'b0, 4'h0, 8'h00, 8'h3F, 1'b0, 8'd6 },  // R6 bits 7:6 zero
    '{6'h00, 1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'd9 }   // R9 released
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rollStrobe = '0; rdEn = 1'b0; rdAddr = '0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irqN in reset", {7'd0, irqN}, 8'h01);
    rstN = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      rollStrobe = VECS[k].strobe; rdEn = VECS[k].rd; rdAddr = VECS[k].ra;
      wrEn = VECS[k].wr; wrAddr = VECS[k].wa; wrData = VECS[k].wd;
      #1;
      check($sformatf("R%0d rdData step %0d", VECS[k].req, k), rdData, VECS[k].expRd);
      check($sformatf("R%0d irqN step %0d", VECS[k].req, k), {7'd0, irqN}, {7'd0, VECS[k].expIrqN});
    end
    // Directed: reset in the middle of activity clears flags and mask (R1)
    @(negedge clk); idle(); rollStrobe = 6'h3F; wrEn = 1'b1; wrAddr = 4'h1; wrData = 8'h3F;
    @(negedge clk); idle();
    #1 check("R8 irq before reset", {7'd0, irqN}, 8'h00);
    rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rdEn = 1'b1; rdAddr = 4'h0;
    #1 check("R1 flags after reset", rdData, 8'h00);
    check("R1 irqN after reset", {7'd0, irqN}, 8'h01);
    @(negedge clk); rdAddr = 4'h1;
    #1 check("R1 mask after reset", rdData, 8'h00);
    @(negedge clk); idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule